// File: doc/BRIEF.md
# Single-Cell Lithium Charge Supervisor

This block is the digital sequencer that sits above the analog loops of a one-cell lithium charger. Comparators and current sensors report the state of the adapter input, the battery voltage and the measured charge current as single-bit flags. From these flags the block picks a charge phase, selects a current setpoint for the analog regulator and drives an open-drain status pin. Safety timers guard the trickle phase and the main charge phase. When one of them runs out, the block latches a fault and blinks the status pin until software or the input clears it.

Time is counted in slow ticks, which the chip supplies as single-cycle strobes. A "minute" is `TICKS_PER_MIN` ticks. The default assumes a 4 Hz tick, so one tick is one half of the 2 Hz blink. While the charger is regulating current, the main-phase timer is throttled by the measured current, so that current lost to system load or to heat does not cause a nuisance timeout. The two input-limit select bits are filtered before use, so that both bits changing at once cannot briefly look like the suspend code.

Top module: `li_charge_ctrl`

## Requirements
- R1: After reset, `mode` is OFF (code 0), `iset_sel` is 0 and `stat_low` is 0 (released).
- R2: From OFF, a cycle starts only if `in_valid` and `chg_en` are high, the filtered limit code is not 2'b11, and `sys_uv` and `therm_sd` are low. The cycle enters PRE (code 1, `iset_sel`=1, one tenth of full current) if `bat_low_pq` is high, and FAST (code 2, `iset_sel`=2, full current) otherwise.
- R3: PRE moves to FAST when `bat_low_pq` drops. If PRE lasts `PREQ_MIN` minutes, the block enters FAULT (code 5).
- R4: FAST moves to TOPOFF (code 3, `iset_sel`=2) when `cv_active` and `topoff_cur` are both high. TOPOFF lasts exactly `TOPOFF_MIN` minutes and then enters DONE (code 4, `iset_sel`=0).
- R5: FAST enters FAULT after `FAST_MIN` minutes of full-rate counting.
- R6: In FAST with `cv_active` low, the timer runs at full rate when `i_ge50` is high. It runs at half rate when only `i_ge20` is high, and it is paused when `i_ge20` is low.
- R7: In FAST with `cv_active` high, the timer runs at full rate whatever the current bands show.
- R8: In DONE, a high `bat_below_rchg` returns the block to FAST with every timer cleared.
- R9: `stat_low` is 1 in PRE and FAST, and 0 in OFF, TOPOFF and DONE.
- R10: In FAULT, `stat_low` starts at 1 and then toggles every `BLINK_HALF` ticks.
- R11: FAULT is left only to OFF, and only when `chg_en` is low, `in_valid` is low, or the filtered limit code is 2'b11. `therm_sd` and `sys_uv` do not clear it.
- R12: Low `in_valid`, high `sys_uv` or high `therm_sd` releases `stat_low` in the same cycle, and moves any charging or DONE state to OFF on the next clock edge.
- R13: `ilim_sel` follows `lim_sel` only after the input has been stable for more than `DEGLITCH` cycles. A code held for only one or two cycles is never passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base strobe, one cycle wide |
| in_valid | input | 1 | Adapter input valid |
| chg_en | input | 1 | Charger enable from software |
| lim_sel | input | 2 | Raw input-limit select; 2'b11 means suspend |
| bat_low_pq | input | 1 | Battery below prequalification level |
| cv_active | input | 1 | Voltage loop in control |
| bat_below_rchg | input | 1 | Battery below recharge level |
| i_ge50 | input | 1 | Charge current at least half of setpoint |
| i_ge20 | input | 1 | Charge current at least one fifth of setpoint |
| topoff_cur | input | 1 | Charge current at or below the top-off level |
| therm_sd | input | 1 | Thermal shutdown |
| sys_uv | input | 1 | System rail undervoltage |
| mode | output | 3 | Phase: 0 OFF, 1 PRE, 2 FAST, 3 TOPOFF, 4 DONE, 5 FAULT |
| iset_sel | output | 2 | Setpoint: 0 none, 1 tenth, 2 full |
| ilim_sel | output | 2 | Filtered input-limit select |
| stat_low | output | 1 | 1 pulls the status pin low; 0 leaves it high impedance |

## Verification
The hardest cases to reach are the throttled-timer outcomes. A fault under half-rate or paused counting only appears after thousands of ticks, and it only appears if the current bands are held steady the whole time. The stimulus shrinks a minute to two ticks. It then holds each band pattern for exactly the number of ticks at which full, half or zero rate would or would not expire, and checks one tick on either side of that boundary. The recharge-clears-timer case is reached the same way. The bench spends part of the FAST budget, finishes top-off into DONE, forces a recharge, and shows that a complete full-rate budget is available again.

// File: rtl/li_charge_ctrl.sv
module li_charge_ctrl #(
  parameter int TICKS_PER_MIN = 240,
  parameter int PREQ_MIN      = 33,
  parameter int FAST_MIN      = 660,
  parameter int TOPOFF_MIN    = 33,
  parameter int BLINK_HALF    = 1,
  parameter int DEGLITCH      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  input  logic       chg_en,
  input  logic [1:0] lim_sel,
  input  logic       bat_low_pq,
  input  logic       cv_active,
  input  logic       bat_below_rchg,
  input  logic       i_ge50,
  input  logic       i_ge20,
  input  logic       topoff_cur,
  input  logic       therm_sd,
  input  logic       sys_uv,
  output logic [2:0] mode,
  output logic [1:0] iset_sel,
  output logic [1:0] ilim_sel,
  output logic       stat_low
);

  localparam int MAXMIN = (FAST_MIN > PREQ_MIN) ?
                          ((FAST_MIN > TOPOFF_MIN) ? FAST_MIN : TOPOFF_MIN) :
                          ((PREQ_MIN > TOPOFF_MIN) ? PREQ_MIN : TOPOFF_MIN);
  localparam int PW = $clog2(TICKS_PER_MIN + 1);
  localparam int MW = $clog2(MAXMIN + 1);
  localparam int BW = $clog2(BLINK_HALF + 1);
  localparam int DW = $clog2(DEGLITCH + 1);

  typedef enum logic [2:0] {
    S_OFF = 3'd0, S_PRE = 3'd1, S_FAST = 3'd2,
    S_TOP = 3'd3, S_DONE = 3'd4, S_FLT = 3'd5
  } st_t;

  st_t st, st_nxt;

  logic [1:0]    lim_q;
  logic [DW-1:0] dg_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lim_q    <= 2'b00;
      ilim_sel <= 2'b00;
      dg_cnt   <= '0;
    end else begin
      lim_q <= lim_sel;
      if (lim_sel != lim_q)            dg_cnt <= '0;
      else if (dg_cnt != DW'(DEGLITCH)) dg_cnt <= dg_cnt + 1'b1;
      if (dg_cnt == DW'(DEGLITCH))     ilim_sel <= lim_q;
    end

  logic suspend, released, run_ok, fault_clr;
  assign suspend   = (ilim_sel == 2'b11);
  assign released  = !in_valid || sys_uv || therm_sd;
  assign run_ok    = !released && chg_en && !suspend;
  assign fault_clr = !chg_en || !in_valid || suspend;

  logic          rate_full, rate_half, half_ph, advance, expired;
  logic [PW-1:0] pre_cnt;
  logic [MW-1:0] min_cnt, limit;

  always_comb begin
    rate_full = 1'b0;
    rate_half = 1'b0;
    limit     = MW'(MAXMIN);
    case (st)
      S_PRE: begin rate_full = 1'b1; limit = MW'(PREQ_MIN); end
      S_TOP: begin rate_full = 1'b1; limit = MW'(TOPOFF_MIN); end
      S_FAST: begin
        limit = MW'(FAST_MIN);
        if (cv_active || i_ge50) rate_full = 1'b1;
        else if (i_ge20)         rate_half = 1'b1;
      end
      default: ;
    endcase
  end

  assign advance = tick && (rate_full || (rate_half && half_ph));
  assign expired = (min_cnt >= limit);

  always_comb begin
    st_nxt = st;
    case (st)
      S_OFF:  if (run_ok) st_nxt = bat_low_pq ? S_PRE : S_FAST;
      S_PRE:  if (!run_ok)                     st_nxt = S_OFF;
              else if (expired)                st_nxt = S_FLT;
              else if (!bat_low_pq)            st_nxt = S_FAST;
      S_FAST: if (!run_ok)                     st_nxt = S_OFF;
              else if (expired)                st_nxt = S_FLT;
              else if (cv_active && topoff_cur) st_nxt = S_TOP;
      S_TOP:  if (!run_ok)                     st_nxt = S_OFF;
              else if (expired)                st_nxt = S_DONE;
      S_DONE: if (!run_ok)                     st_nxt = S_OFF;
              else if (bat_below_rchg)         st_nxt = S_FAST;
      S_FLT:  if (fault_clr)                   st_nxt = S_OFF;
      default:                                 st_nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_OFF;
    else        st <= st_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      min_cnt <= '0;
      half_ph <= 1'b0;
    end else if (st_nxt != st) begin
      pre_cnt <= '0;
      min_cnt <= '0;
      half_ph <= 1'b0;
    end else begin
      if (tick && rate_half) half_ph <= !half_ph;
      if (advance) begin
        if (pre_cnt == PW'(TICKS_PER_MIN - 1)) begin
          pre_cnt <= '0;
          min_cnt <= min_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end

  logic [BW-1:0] blk_cnt;
  logic          blk_ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blk_cnt <= '0;
      blk_ph  <= 1'b1;
    end else if (st != S_FLT) begin
      blk_cnt <= '0;
      blk_ph  <= 1'b1;
    end else if (tick) begin
      if (blk_cnt == BW'(BLINK_HALF - 1)) begin
        blk_cnt <= '0;
        blk_ph  <= !blk_ph;
      end else begin
        blk_cnt <= blk_cnt + 1'b1;
      end
    end

  assign mode     = st;
  assign iset_sel = (st == S_PRE) ? 2'd1 :
                    (st == S_FAST || st == S_TOP) ? 2'd2 : 2'd0;
  assign stat_low = !released &&
                    (st == S_PRE || st == S_FAST || (st == S_FLT && blk_ph));

endmodule

module li_charge_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       chg_en,
  input logic       sys_uv,
  input logic       therm_sd,
  input logic [2:0] mode,
  input logic [1:0] ilim_sel,
  input logic       stat_low
);

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd5);

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd0 && mode != 3'd0) |->
      ($past(chg_en) && $past(in_valid) && (mode == 3'd1 || mode == 3'd2)));

  assert_done_from_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && $past(mode) != 3'd4) |-> $past(mode) == 3'd3);

  assert_fault_from_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && $past(mode) != 3'd5) |->
      ($past(mode) == 3'd1 || $past(mode) == 3'd2));

  assert_stat_states_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_low |-> (mode == 3'd1 || mode == 3'd2 || mode == 3'd5));

  assert_fault_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd5 && mode != 3'd5) |-> mode == 3'd0);

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && chg_en && in_valid && ilim_sel != 2'b11) |=> mode == 3'd5);

  assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || sys_uv || therm_sd) |-> !stat_low);

endmodule

bind li_charge_ctrl li_charge_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chg_en(chg_en),
  .sys_uv(sys_uv), .therm_sd(therm_sd), .mode(mode),
  .ilim_sel(ilim_sel), .stat_low(stat_low)
);

// File: tb/sim_li_charge_ctrl.sv
module sim_li_charge_ctrl;
  localparam int TPM = 2;
  localparam int PREQ = 33;
  localparam int FAST = 660;
  localparam int TOP = 33;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic in_valid = 1'b0, chg_en = 1'b0, bat_low_pq = 1'b0, cv_active = 1'b0;
  logic bat_below_rchg = 1'b0, i_ge50 = 1'b0, i_ge20 = 1'b0, topoff_cur = 1'b0;
  logic therm_sd = 1'b0, sys_uv = 1'b0;
  logic [1:0] lim_sel = 2'b00;
  logic [2:0] mode;
  logic [1:0] iset_sel, ilim_sel;
  logic stat_low;
  int checks = 0, fails = 0;

  always #10 clk = !clk;

  li_charge_ctrl #(.TICKS_PER_MIN(TPM), .PREQ_MIN(PREQ), .FAST_MIN(FAST),
    .TOPOFF_MIN(TOP), .BLINK_HALF(2), .DEGLITCH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .chg_en(chg_en),
    .lim_sel(lim_sel), .bat_low_pq(bat_low_pq), .cv_active(cv_active),
    .bat_below_rchg(bat_below_rchg), .i_ge50(i_ge50), .i_ge20(i_ge20),
    .topoff_cur(topoff_cur), .therm_sd(therm_sd), .sys_uv(sys_uv),
    .mode(mode), .iset_sel(iset_sel), .ilim_sel(ilim_sel), .stat_low(stat_low));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic go_off();
    chg_en = 1'b0; cv_active = 1'b0; topoff_cur = 1'b0; bat_below_rchg = 1'b0;
    cyc(2);
  endtask

  task automatic start_fast(input logic ge50, input logic ge20, input logic cv);
    go_off();
    i_ge50 = ge50; i_ge20 = ge20; cv_active = cv; bat_low_pq = 1'b0;
    chg_en = 1'b1;
    cyc(2);
  endtask

  task automatic t_reset();
    chk("R1 mode after reset", mode, 0);
    chk("R1 iset after reset", iset_sel, 0);
    chk("R1 stat after reset", stat_low, 0);
  endtask

  task automatic t_start();
    in_valid = 1'b1; bat_low_pq = 1'b1; cyc(3);
    chk("R2 no start without enable", mode, 0);
    chg_en = 1'b1; cyc(2);
    chk("R2 start into PRE", mode, 1);
    chk("R2 PRE setpoint tenth", iset_sel, 1);
    chk("R9 stat low in PRE", stat_low, 1);
    bat_low_pq = 1'b0; cyc(2);
    chk("R3 PRE to FAST", mode, 2);
    chk("R2 FAST setpoint full", iset_sel, 2);
    chk("R9 stat low in FAST", stat_low, 1);
  endtask

  task automatic t_preq_fault();
    go_off();
    bat_low_pq = 1'b1; chg_en = 1'b1; cyc(2);
    ticks(PREQ * TPM - 1); cyc(1);
    chk("R3 PRE not yet expired", mode, 1);
    ticks(1); cyc(1);
    chk("R3 PRE timeout to FAULT", mode, 5);
    chk("R10 blink starts low", stat_low, 1);
    ticks(2);
    chk("R10 blink released half", stat_low, 0);
    ticks(2);
    chk("R10 blink low again", stat_low, 1);
    therm_sd = 1'b1; cyc(3);
    chk("R11 thermal keeps FAULT", mode, 5);
    chk("R12 thermal releases stat", stat_low, 0);
    therm_sd = 1'b0; cyc(1);
    chg_en = 1'b0; cyc(2);
    chk("R11 enable low clears FAULT", mode, 0);
    bat_low_pq = 1'b0;
  endtask

  task automatic t_fast_full();
    start_fast(1'b1, 1'b1, 1'b0);
    ticks(FAST * TPM - 1); cyc(1);
    chk("R5 FAST not yet expired", mode, 2);
    ticks(1); cyc(1);
    chk("R5 FAST timeout to FAULT", mode, 5);
    in_valid = 1'b0; cyc(2);
    chk("R11 input removal clears FAULT", mode, 0);
    in_valid = 1'b1;
  endtask

  task automatic t_fast_half();
    start_fast(1'b0, 1'b1, 1'b0);
    ticks(2 * FAST * TPM - 1); cyc(1);
    chk("R6 half rate not yet expired", mode, 2);
    ticks(1); cyc(1);
    chk("R6 half rate expiry", mode, 5);
    lim_sel = 2'b11; cyc(12);
    chk("R13 suspend code passes filter", ilim_sel, 3);
    chk("R11 suspend clears FAULT", mode, 0);
    lim_sel = 2'b00; cyc(12);
  endtask

  task automatic t_fast_pause();
    start_fast(1'b0, 1'b0, 1'b0);
    ticks(1500); cyc(1);
    chk("R6 paused timer no fault", mode, 2);
    i_ge50 = 1'b1;
    ticks(FAST * TPM - 1); cyc(1);
    chk("R6 pause kept count at zero", mode, 2);
    ticks(1); cyc(1);
    chk("R6 full budget after pause", mode, 5);
  endtask

  task automatic t_fast_cv();
    start_fast(1'b0, 1'b0, 1'b1);
    ticks(FAST * TPM - 1); cyc(1);
    chk("R7 CV full rate not yet expired", mode, 2);
    ticks(1); cyc(1);
    chk("R7 CV ignores current bands", mode, 5);
  endtask

  task automatic t_topoff_recharge();
    start_fast(1'b1, 1'b1, 1'b0);
    ticks(1000);
    cv_active = 1'b1; topoff_cur = 1'b1; cyc(2);
    chk("R4 enter TOPOFF", mode, 3);
    chk("R9 stat released in TOPOFF", stat_low, 0);
    chk("R4 TOPOFF setpoint", iset_sel, 2);
    ticks(TOP * TPM - 1); cyc(1);
    chk("R4 TOPOFF still running", mode, 3);
    ticks(1); cyc(1);
    chk("R4 TOPOFF to DONE", mode, 4);
    chk("R9 stat released in DONE", stat_low, 0);
    chk("R4 DONE setpoint none", iset_sel, 0);
    cv_active = 1'b0; topoff_cur = 1'b0; bat_below_rchg = 1'b1; cyc(2);
    chk("R8 recharge to FAST", mode, 2);
    bat_below_rchg = 1'b0;
    ticks(FAST * TPM - 1); cyc(1);
    chk("R8 timer cleared on recharge", mode, 2);
    ticks(1); cyc(1);
    chk("R8 fresh budget expires exactly", mode, 5);
  endtask

  task automatic t_glitch();
    start_fast(1'b1, 1'b1, 1'b0);
    lim_sel = 2'b01; cyc(12);
    chk("R13 filtered code follows", ilim_sel, 1);
    lim_sel = 2'b11; cyc(2);
    lim_sel = 2'b10; cyc(12);
    chk("R13 short suspend ignored", mode, 2);
    chk("R13 filtered settles", ilim_sel, 2);
    lim_sel = 2'b00; cyc(12);
  endtask

  task automatic t_release();
    start_fast(1'b1, 1'b1, 1'b0);
    @(negedge clk) sys_uv = 1'b1; #1;
    chk("R12 undervoltage releases stat at once", stat_low, 0);
    cyc(2);
    chk("R12 undervoltage stops charge", mode, 0);
    chk("R9 stat released in OFF", stat_low, 0);
    sys_uv = 1'b0; cyc(2);
    chk("R2 restart after undervoltage", mode, 2);
    in_valid = 1'b0; cyc(2);
    chk("R12 input loss stops charge", mode, 0);
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_start();
    t_preq_fault();
    t_fast_full();
    t_fast_half();
    t_fast_pause();
    t_fast_cv();
    t_topoff_recharge();
    t_glitch();
    t_release();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule